// File: doc/BRIEF.md
# Instrument Status Register Group

This block reports the health of a set of monitored circuits to a host. Sixteen live condition lines are sampled every clock. Any line seen high is captured in a sticky event register. The event register keeps the bit until the host reads it, and that read clears it. A host-programmed enable mask selects which captured events count. Those events are OR-reduced into a summary bit at bit 7 of an 8-bit status byte. The other seven status byte bits come from neighbouring status sources through a side input.

A second host-programmed mask, the request-enable mask, selects which status byte bits raise the service-request line. The host uses a small register port to reach everything. The port has a 2-bit address, a one-cycle write strobe, and a read strobe whose data appears one clock later.

Top module: `stat_group_top`

## Requirements
- R1: A read of address 0 (condition) returns the value of `cond_i` at the clock edge that samples the read strobe.
- R2: An event bit becomes 1 at any clock edge where the matching `cond_i` bit is 1. It stays 1 through any number of cycles until an event read.
- R3: A read of address 1 (event) returns the event register's contents and clears every event bit at the same edge.
- R4: If a `cond_i` bit is 1 at the edge of an event read, that event bit is 1 after the read.
- R5: Address 2 holds the 16-bit event-enable mask. A write stores `wdata_i`, and a read returns the stored mask.
- R6: Status byte bit 7 equals the OR of (event AND enable) as it stood one clock earlier, so it updates on the edge after an event is latched.
- R7: `srq_o` is 1 exactly when the registered status byte AND the request-enable mask is nonzero.
- R8: After reset, the event, enable, status byte, request-enable and read data registers are zero, `rdata_valid_o` is 0 and `srq_o` is 0.
- R9: `rdata_valid_o` is 1 in the cycle after a cycle with `rd_en_i` high and 0 otherwise. `rdata_o` carries the read data while it is 1.
- R10: Writes to address 0 or address 1 change no state.
- R11: A read of address 3 returns the request-enable mask in bits 15:8 and the status byte in bits 7:0. A write to address 3 loads the request-enable mask from `wdata_i[15:8]` and leaves the status byte untouched.
- R12: Status byte bits 6:0 take `sb_other_i[6:0]` one clock later. `sb_other_i[7]` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cond_i | input | 16 | Live condition lines |
| sb_other_i | input | 8 | Other status byte sources (bit 7 unused) |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address: 0 condition, 1 event, 2 enable, 3 status byte / request mask |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid one clock after the strobe |
| rdata_valid_o | output | 1 | Read data valid |
| srq_o | output | 1 | Service request |

## Verification
The bench drives a condition bit that is high in the same cycle as an event read. A design that clears first and ignores the incoming condition would drop that event and read back zero afterwards. The bench checks the one-clock lag between a latched event and status bit 7. A design that forms the summary combinationally would raise `srq_o` one cycle early, and a design with an extra stage would raise it one cycle late. The bench writes to the read-only addresses and to the status byte half of address 3. A decoder that lets those writes through would corrupt the event register or the status byte. Sparse random conditions mixed with random reads and mask writes then exercise the clear-on-read race under many orderings.

// File: rtl/stat_pkg.sv
package stat_pkg;

    // Register port address map
    typedef enum logic [1:0] {
        ADDR_COND   = 2'd0,
        ADDR_EVENT  = 2'd1,
        ADDR_ENABLE = 2'd2,
        ADDR_SBYTE  = 2'd3
    } stat_addr_e;

    localparam int unsigned COND_W_DEF  = 16;
    localparam int unsigned SB_W_DEF    = 8;
    localparam int unsigned SUM_POS_DEF = 7;

endpackage

// File: rtl/stat_event_bank.sv
module stat_event_bank #(
    parameter int unsigned W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] cond_i,
    input  logic         clr_i,
    input  logic         en_we_i,
    input  logic [W-1:0] en_wdata_i,
    output logic [W-1:0] evt_o,
    output logic [W-1:0] en_o,
    output logic         hit_o
);

    typedef struct packed {
        logic [W-1:0] evt;
        logic [W-1:0] en;
    } bank_t;

    bank_t        st_d, st_q;
    logic [W-1:0] evt_nx;

    // Per-bit sticky cell: a read clears, but a live condition wins
    for (genvar g = 0; g < W; g++) begin : g_cell
        assign evt_nx[g] = (st_q.evt[g] & ~clr_i) | cond_i[g];
    end

    always_comb begin
        st_d     = st_q;
        st_d.evt = evt_nx;
        if (en_we_i) begin
            st_d.en = en_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o = st_q.evt;
    assign en_o  = st_q.en;
    assign hit_o = |(st_q.evt & st_q.en);

endmodule

// File: rtl/stat_sbyte.sv
module stat_sbyte #(
    parameter int unsigned SB_W    = 8,
    parameter int unsigned SUM_POS = 7
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            summary_i,
    input  logic [SB_W-1:0] other_i,
    input  logic            sre_we_i,
    input  logic [SB_W-1:0] sre_wdata_i,
    output logic [SB_W-1:0] stb_o,
    output logic [SB_W-1:0] sre_o,
    output logic            srq_o
);

    typedef struct packed {
        logic [SB_W-1:0] stb;
        logic [SB_W-1:0] sre;
    } sbyte_t;

    sbyte_t st_d, st_q;

    always_comb begin
        st_d              = st_q;
        st_d.stb          = other_i;
        st_d.stb[SUM_POS] = summary_i;
        if (sre_we_i) begin
            st_d.sre = sre_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o = st_q.stb;
    assign sre_o = st_q.sre;
    assign srq_o = |(st_q.stb & st_q.sre);

endmodule

// File: rtl/stat_regport.sv
module stat_regport
    import stat_pkg::*;
#(
    parameter int unsigned DW   = 16,
    parameter int unsigned SB_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            rd_en_i,
    input  logic            wr_en_i,
    input  logic [1:0]      addr_i,
    input  logic [DW-1:0]   cond_i,
    input  logic [DW-1:0]   evt_i,
    input  logic [DW-1:0]   en_i,
    input  logic [SB_W-1:0] stb_i,
    input  logic [SB_W-1:0] sre_i,
    output logic [DW-1:0]   rdata_o,
    output logic            rdata_valid_o,
    output logic            evt_clr_o,
    output logic            en_we_o,
    output logic            sre_we_o
);

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          valid;
    } port_t;

    port_t         st_d, st_q;
    logic [DW-1:0] sb_word;

    always_comb begin
        sb_word                = '0;
        sb_word[2*SB_W-1:0]    = {sre_i, stb_i};
    end

    // Address 0 and 1 have no write decode: writes there are dropped
    assign evt_clr_o = rd_en_i && (addr_i == ADDR_EVENT);
    assign en_we_o   = wr_en_i && (addr_i == ADDR_ENABLE);
    assign sre_we_o  = wr_en_i && (addr_i == ADDR_SBYTE);

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_en_i;
        if (rd_en_i) begin
            unique case (stat_addr_e'(addr_i))
                ADDR_COND:   st_d.rdata = cond_i;
                ADDR_EVENT:  st_d.rdata = evt_i;
                ADDR_ENABLE: st_d.rdata = en_i;
                ADDR_SBYTE:  st_d.rdata = sb_word;
                default:     st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o       = st_q.rdata;
    assign rdata_valid_o = st_q.valid;

endmodule

// File: rtl/stat_group_top.sv
module stat_group_top
    import stat_pkg::*;
#(
    parameter int unsigned COND_W  = COND_W_DEF,
    parameter int unsigned SB_W    = SB_W_DEF,
    parameter int unsigned SUM_POS = SUM_POS_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [COND_W-1:0] cond_i,
    input  logic [SB_W-1:0]   sb_other_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [COND_W-1:0] wdata_i,
    output logic [COND_W-1:0] rdata_o,
    output logic              rdata_valid_o,
    output logic              srq_o
);

    localparam int unsigned SRE_LSB = SB_W;

    logic [COND_W-1:0] evt_w, en_w;
    logic [SB_W-1:0]   stb_w, sre_w;
    logic              hit_w, evt_clr_w, en_we_w, sre_we_w;

    stat_event_bank #(.W(COND_W)) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cond_i     (cond_i),
        .clr_i      (evt_clr_w),
        .en_we_i    (en_we_w),
        .en_wdata_i (wdata_i),
        .evt_o      (evt_w),
        .en_o       (en_w),
        .hit_o      (hit_w)
    );

    stat_sbyte #(.SB_W(SB_W), .SUM_POS(SUM_POS)) u_sbyte (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .summary_i   (hit_w),
        .other_i     (sb_other_i),
        .sre_we_i    (sre_we_w),
        .sre_wdata_i (wdata_i[SRE_LSB +: SB_W]),
        .stb_o       (stb_w),
        .sre_o       (sre_w),
        .srq_o       (srq_o)
    );

    stat_regport #(.DW(COND_W), .SB_W(SB_W)) u_port (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .rd_en_i       (rd_en_i),
        .wr_en_i       (wr_en_i),
        .addr_i        (addr_i),
        .cond_i        (cond_i),
        .evt_i         (evt_w),
        .en_i          (en_w),
        .stb_i         (stb_w),
        .sre_i         (sre_w),
        .rdata_o       (rdata_o),
        .rdata_valid_o (rdata_valid_o),
        .evt_clr_o     (evt_clr_w),
        .en_we_o       (en_we_w),
        .sre_we_o      (sre_we_w)
    );

endmodule

// File: rtl/stat_group_chk.sv
module stat_group_chk #(
    parameter int unsigned COND_W  = 16,
    parameter int unsigned SB_W    = 8,
    parameter int unsigned SUM_POS = 7
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [COND_W-1:0] cond_i,
    input logic              rd_en_i,
    input logic              wr_en_i,
    input logic [1:0]        addr_i,
    input logic              rdata_valid_o,
    input logic [COND_W-1:0] evt_q,
    input logic [COND_W-1:0] en_q,
    input logic [SB_W-1:0]   stb_q
);

    assert_evt_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_en_i && addr_i == 2'd1) |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

    assert_cond_latched_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((evt_q & $past(cond_i)) == $past(cond_i)));

    assert_evt_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == 2'd1) |=> (evt_q == $past(cond_i)));

    assert_en_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && addr_i == 2'd2) |=> $stable(en_q));

    assert_summary_lag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (stb_q[SUM_POS] == (|($past(evt_q) & $past(en_q)))));

    assert_valid_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rdata_valid_o);

    assert_valid_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> !rdata_valid_o);

endmodule

bind stat_group_top stat_group_chk #(
    .COND_W  (COND_W),
    .SB_W    (SB_W),
    .SUM_POS (SUM_POS)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cond_i        (cond_i),
    .rd_en_i       (rd_en_i),
    .wr_en_i       (wr_en_i),
    .addr_i        (addr_i),
    .rdata_valid_o (rdata_valid_o),
    .evt_q         (evt_w),
    .en_q          (en_w),
    .stb_q         (stb_w)
);

// File: tb/stat_group_top_tb.sv
module stat_group_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cond = '0;
    logic [7:0]  other = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    string       tag_in = "R9";
    logic [15:0] rdata;
    logic        rvalid, srq;

    int vectors = 0;
    int fails = 0;

    // Reference model state
    logic [15:0] m_evt, m_en, m_rdata;
    logic [7:0]  m_stb, m_sre;
    logic        m_valid;
    string       m_tag = "R9";

    always #4 clk = ~clk;

    stat_group_top u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cond_i        (cond),
        .sb_other_i    (other),
        .rd_en_i       (rd),
        .wr_en_i       (wr),
        .addr_i        (addr),
        .wdata_i       (wdata),
        .rdata_o       (rdata),
        .rdata_valid_o (rvalid),
        .srq_o         (srq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_evt = '0; m_en = '0; m_rdata = '0;
            m_stb = '0; m_sre = '0; m_valid = 1'b0;
        end else begin
            logic [15:0] evt_old, en_old;
            evt_old = m_evt;
            en_old  = m_en;
            m_valid = rd;
            if (rd) begin
                m_tag = tag_in;
                case (addr)
                    2'd0: m_rdata = cond;
                    2'd1: m_rdata = m_evt;
                    2'd2: m_rdata = m_en;
                    default: m_rdata = {m_sre, m_stb};
                endcase
            end
            m_evt = ((rd && addr == 2'd1) ? 16'h0 : m_evt) | cond;
            if (wr && addr == 2'd2) m_en = wdata;
            if (wr && addr == 2'd3) m_sre = wdata[15:8];
            m_stb = {(evt_old & en_old) != 16'h0, other[6:0]};
        end
    end

    task automatic check_all();
        logic exp_srq;
        exp_srq = (m_stb & m_sre) != 8'h0;
        vectors++;
        if (rvalid !== m_valid) begin
            fails++;
            $display("FAIL R9: rdata_valid_o actual %b expected %b", rvalid, m_valid);
        end
        vectors++;
        if (srq !== exp_srq) begin
            fails++;
            $display("FAIL R7: srq_o actual %b expected %b", srq, exp_srq);
        end
        if (m_valid) begin
            vectors++;
            if (rdata !== m_rdata) begin
                fails++;
                $display("FAIL %s: rdata_o actual %h expected %h", m_tag, rdata, m_rdata);
            end
        end
    endtask

    task automatic tick(input logic r, input logic w, input logic [1:0] a,
                        input logic [15:0] wd, input logic [15:0] c,
                        input logic [7:0] o, input string t);
        @(negedge clk);
        if (rst_n) check_all();
        rd = r; wr = w; addr = a; wdata = wd; cond = c; other = o; tag_in = t;
    endtask

    task automatic idle(input int n, input logic [7:0] o);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 2'd0, 16'h0, 16'h0, o, "R9");
    endtask

    function automatic string tag_for(input logic [1:0] a);
        case (a)
            2'd0: return "R1";
            2'd1: return "R3";
            2'd2: return "R5";
            default: return "R11";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: everything zero after reset
        vectors++;
        if (rvalid !== 1'b0 || srq !== 1'b0) begin
            fails++;
            $display("FAIL R8: valid/srq actual %b%b expected 00", rvalid, srq);
        end
        for (int a = 0; a < 4; a++) tick(1'b1, 1'b0, 2'(a), 16'h0, 16'h0, 8'h0, "R8");
        idle(1, 8'h0);
        // R1: live condition read
        tick(1'b1, 1'b0, 2'd0, 16'h0, 16'hA5A5, 8'h0, "R1");
        tick(1'b1, 1'b0, 2'd1, 16'h0, 16'h0, 8'h0, "R3");   // clear what R1 latched
        // R2: one-cycle pulse stays latched
        tick(1'b0, 1'b0, 2'd0, 16'h0, 16'h0008, 8'h0, "R2");
        idle(5, 8'h0);
        tick(1'b1, 1'b0, 2'd1, 16'h0, 16'h0, 8'h0, "R2");
        tick(1'b1, 1'b0, 2'd1, 16'h0, 16'h0, 8'h0, "R3");   // second read returns zero
        // R4: condition high during the clearing read
        tick(1'b1, 1'b0, 2'd1, 16'h0, 16'h0020, 8'h0, "R4");
        tick(1'b1, 1'b0, 2'd1, 16'h0, 16'h0, 8'h0, "R4");
        // R5: enable mask write and readback
        tick(1'b0, 1'b1, 2'd2, 16'h0020, 16'h0, 8'h0, "R5");
        tick(1'b1, 1'b0, 2'd2, 16'h0, 16'h0, 8'h0, "R5");
        // R6: masked event reaches status bit 7 one clock later
        tick(1'b0, 1'b0, 2'd0, 16'h0, 16'h0020, 8'h0, "R6");
        tick(1'b1, 1'b0, 2'd3, 16'h0, 16'h0, 8'h0, "R6");
        tick(1'b1, 1'b0, 2'd3, 16'h0, 16'h0, 8'h0, "R6");
        // R11: request mask write leaves status byte half alone; R7 via srq
        tick(1'b0, 1'b1, 2'd3, 16'h80FF, 16'h0, 8'h0, "R11");
        tick(1'b1, 1'b0, 2'd3, 16'h0, 16'h0, 8'h0, "R11");
        idle(2, 8'h0);
        // R10: writes to read-only addresses dropped
        tick(1'b0, 1'b1, 2'd1, 16'h0000, 16'h0, 8'h0, "R10");
        tick(1'b0, 1'b1, 2'd0, 16'hFFFF, 16'h0, 8'h0, "R10");
        tick(1'b1, 1'b0, 2'd1, 16'h0, 16'h0, 8'h0, "R10");
        tick(1'b1, 1'b0, 2'd2, 16'h0, 16'h0, 8'h0, "R10");
        // R12: side status bits, bit 7 of the side input ignored
        tick(1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 8'hD5, "R12");
        tick(1'b1, 1'b0, 2'd3, 16'h0, 16'h0, 8'hD5, "R12");
        tick(1'b1, 1'b0, 2'd3, 16'h0, 16'h0, 8'h80, "R12");
        idle(2, 8'h0);
        // Random traffic compared every clock
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] a;
            logic       r, w;
            a = 2'($urandom_range(0, 3));
            r = ($urandom_range(0, 9) < 3);
            w = ($urandom_range(0, 9) < 2);
            tick(r, w, a, 16'($urandom), 16'($urandom & $urandom & $urandom),
                 8'($urandom), tag_for(a));
        end
        idle(3, 8'h0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule